// File: doc/BRIEF.md
# Compressor-Tree Unsigned Multiplier

This block multiplies two unsigned operands and returns the full double-width product. It is purely combinational. There are three stages. An AND array first forms one shifted partial-product row for each multiplier bit. A tree of (4,2) compressor rows then halves the number of rows at each level until two rows remain. A parallel-prefix carry-propagate adder adds those two rows to give the product.

Each (4,2) cell is two full adders in series. Its first carry output is passed sideways to the cell one bit position higher in the same row, so the row adds four vectors with no ripple through the cell's own sum path. The default build is 8 x 8 bits with a 16-bit product. The operand width is a parameter and must be a power of two of at least four.

Top module: `cmp42_mult`

## Requirements
- R1: `product` equals the unsigned product `mcand * mplier` for every operand pair, and it is valid in the same cycle the operands are applied, with no register on the path.
- R2: Each (4,2) cell feeds x1, x2 and x3 into a first full adder, which gives the lateral carry-out and a partial sum. A second full adder takes the partial sum, x4 and the lateral carry-in, and gives the cell sum and carry. The five inputs add up to sum + 2*(carry + lateral carry-out).
- R3: In a compressor row, the lateral carry-out of bit i drives the lateral carry-in of bit i+1, and the carry-in of bit 0 is 0. The row turns four vectors into a sum vector and a carry vector shifted one place left, and the arithmetic total is kept exactly.
- R4: The tree halves the row count at each level until two rows remain. For 8-bit operands this takes two levels (8 to 4 to 2 rows), and every active level leaves a correct product, for example 0x12 * 0x34 = 0x03A8.
- R5: The final adder is a Kogge-Stone parallel-prefix adder of width 2N with log2(2N) combine stages. It adds the two reduced rows, including long carry runs such as 0x0F * 0x0F = 0x00E1.
- R6: The final adder never produces a carry out of bit 2N-1. The largest result, 0xFF * 0xFF, is 0xFE01.
- R7: A zero on either operand gives a product of 0x0000.
- R8: An operand equal to 2^k gives the other operand shifted left by k bits, for example 0x80 * 0x80 = 0x4000 and 0x01 * 0xFF = 0x00FF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mcand | input | N (8) | Unsigned multiplicand |
| mplier | input | N (8) | Unsigned multiplier; bit r selects partial-product row r |
| product | output | 2N (16) | Unsigned full-width product |

## Verification
Every result of this block is due zero cycles after its stimulus, because no register lies between the operand inputs and `product`. The bench drives the operands just after a rising clock edge. It samples `product` at the following falling edge, half a period later, when the combinational path has settled, and it never looks across a rising edge. The bench first walks a table of vectors whose expected products were worked out by hand: zero, power-of-two, all-ones and alternating-bit operands. It then sweeps every operand pair and compares each result with a reference multiply computed inside the bench.

// File: rtl/cmp42_pkg.sv
// Package cmp42_pkg
// Purpose: shared constants and full-adder helper functions for the
//          compressor-tree multiplier.
// Assumes: functions are used on single-bit operands only.
package cmp42_pkg;

    // Default operand width of the multiplier.
    localparam int unsigned CMP42_DEF_N = 8;

    // Sum output of a (3,2) counter.
    function automatic logic fa_sum(input logic a, input logic b, input logic c);
        return a ^ b ^ c;
    endfunction

    // Carry output of a (3,2) counter (majority of the inputs).
    function automatic logic fa_carry(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

endpackage

// File: rtl/cmp42_fa.sv
// Module cmp42_fa
// Purpose: a (3,2) counter (full adder). It turns three equal-weight bits
//          into a sum bit and a carry bit of double weight.
// Assumes: nothing beyond single-bit inputs.
module cmp42_fa
    import cmp42_pkg::*;
(
    input  logic in_a,
    input  logic in_b,
    input  logic in_c,
    output logic sum_o,
    output logic carry_o
);

    // Count the three input bits.
    always_comb begin
        sum_o   = fa_sum(in_a, in_b, in_c);
        carry_o = fa_carry(in_a, in_b, in_c);
    end

endmodule

// File: rtl/cmp42_cell.sv
// Module cmp42_cell
// Purpose: one (4,2) compressor cell made of two (3,2) counters in series.
//          The first counter adds x1..x3 and gives the lateral carry-out.
//          The second adds the partial sum, x4 and the lateral carry-in.
// Assumes: all five inputs carry the same weight. lat_cout and carry_o
//          carry twice that weight.
module cmp42_cell (
    input  logic x1,
    input  logic x2,
    input  logic x3,
    input  logic x4,
    input  logic lat_cin,
    output logic sum_o,
    output logic carry_o,
    output logic lat_cout
);

    logic part_sum;

    // First counter: external bits x1..x3.
    cmp42_fa u_fa_first (
        .in_a    (x1),
        .in_b    (x2),
        .in_c    (x3),
        .sum_o   (part_sum),
        .carry_o (lat_cout)
    );

    // Second counter: partial sum, x4 and the neighbour's lateral carry.
    cmp42_fa u_fa_second (
        .in_a    (part_sum),
        .in_b    (x4),
        .in_c    (lat_cin),
        .sum_o   (sum_o),
        .carry_o (carry_o)
    );

    // Check that the cell keeps the weighted count of its five inputs.
    always_comb begin
        AST_CELL_COUNT: assert (3'(x1) + 3'(x2) + 3'(x3) + 3'(x4) + 3'(lat_cin)
                                == 3'(sum_o) + 3'({carry_o, 1'b0}) + 3'({lat_cout, 1'b0}))
            else $error("cell count mismatch"); // R2
    end

endmodule

// File: rtl/cmp42_row.sv
// Module cmp42_row
// Purpose: compresses four W-bit vectors into a sum vector and a carry
//          vector with a row of (4,2) cells. Each cell's lateral carry
//          feeds the cell one bit higher.
// Assumes: the caller knows the true total fits in W bits, so the carries
//          leaving bit W-1 are zero and are dropped.
module cmp42_row #(
    parameter int unsigned W = 16
) (
    input  logic [W-1:0] row_a,
    input  logic [W-1:0] row_b,
    input  logic [W-1:0] row_c,
    input  logic [W-1:0] row_d,
    output logic [W-1:0] row_sum,
    output logic [W-1:0] row_carry
);

    logic [W:0]   lat_chain;
    logic [W-1:0] cell_carry;

    // Bit 0 has no lower neighbour, so its lateral carry-in is zero.
    assign lat_chain[0] = 1'b0;

    generate
        for (genvar i = 0; i < W; i++) begin : g_cell
            cmp42_cell u_cell (
                .x1       (row_a[i]),
                .x2       (row_b[i]),
                .x3       (row_c[i]),
                .x4       (row_d[i]),
                .lat_cin  (lat_chain[i]),
                .sum_o    (row_sum[i]),
                .carry_o  (cell_carry[i]),
                .lat_cout (lat_chain[i+1])
            );
        end
    endgenerate

    // Move the cell carries up one place to give the carry vector.
    always_comb begin
        row_carry = {cell_carry[W-2:0], 1'b0};
    end

    // Check that the row keeps the exact total, counting the bits that leave the top.
    always_comb begin
        AST_ROW_EXACT: assert ((W+2)'(row_a) + (W+2)'(row_b) + (W+2)'(row_c) + (W+2)'(row_d)
                               == (W+2)'(row_sum) + (W+2)'(row_carry)
                                  + (W+2)'({cell_carry[W-1], {W{1'b0}}})
                                  + (W+2)'({lat_chain[W], {W{1'b0}}}))
            else $error("row total mismatch"); // R3
    end

endmodule

// File: rtl/cmp42_tree.sv
// Module cmp42_tree
// Purpose: reduces ROWS W-bit rows to two rows. Each level groups the rows
//          in fours and halves the count, and the module recurses until
//          two rows are left.
// Assumes: ROWS is a power of two of at least 2. Row r sits at
//          rows_in[r*W +: W].
module cmp42_tree #(
    parameter int unsigned W    = 16,
    parameter int unsigned ROWS = 8
) (
    input  logic [ROWS*W-1:0] rows_in,
    output logic [W-1:0]      out_sum,
    output logic [W-1:0]      out_carry
);

    localparam int unsigned NEXT_ROWS = ROWS / 2;
    localparam int unsigned GROUPS    = ROWS / 4;

    generate
        if (ROWS == 2) begin : g_leaf
            // Two rows left: hand them straight to the adder.
            always_comb begin
                out_sum   = rows_in[W-1:0];
                out_carry = rows_in[2*W-1:W];
            end
        end else begin : g_level
            logic [NEXT_ROWS*W-1:0] next_rows;

            for (genvar g = 0; g < GROUPS; g++) begin : g_group
                cmp42_row #(.W(W)) u_row (
                    .row_a     (rows_in[(4*g+0)*W +: W]),
                    .row_b     (rows_in[(4*g+1)*W +: W]),
                    .row_c     (rows_in[(4*g+2)*W +: W]),
                    .row_d     (rows_in[(4*g+3)*W +: W]),
                    .row_sum   (next_rows[(2*g+0)*W +: W]),
                    .row_carry (next_rows[(2*g+1)*W +: W])
                );
            end

            cmp42_tree #(.W(W), .ROWS(NEXT_ROWS)) u_sub (
                .rows_in   (next_rows),
                .out_sum   (out_sum),
                .out_carry (out_carry)
            );
        end
    endgenerate

endmodule

// File: rtl/cmp42_prefix_add.sv
// Module cmp42_prefix_add
// Purpose: W-bit Kogge-Stone parallel-prefix adder. It works out all the
//          carries in log2(W) combine stages.
// Assumes: W is a power of two. There is no carry-in. The carry-out is
//          given so that the caller can check it.
module cmp42_prefix_add #(
    parameter int unsigned W = 16
) (
    input  logic [W-1:0] add_x,
    input  logic [W-1:0] add_y,
    output logic [W-1:0] add_sum,
    output logic         add_cout
);

    localparam int unsigned STAGES = $clog2(W);

    logic [W-1:0] gen_q  [0:STAGES];
    logic [W-1:0] prop_q [0:STAGES-1];
    logic [W-1:0] half_sum;

    // Generate and propagate terms for each bit.
    always_comb begin
        gen_q[0]  = add_x & add_y;
        prop_q[0] = add_x ^ add_y;
        half_sum  = add_x ^ add_y;
    end

    generate
        for (genvar k = 0; k < STAGES; k++) begin : g_stage
            localparam int unsigned DIST = 1 << k;
            for (genvar i = 0; i < W; i++) begin : g_bit
                if (i >= DIST) begin : g_comb
                    // Merge with the group DIST places lower.
                    assign gen_q[k+1][i] = gen_q[k][i] | (prop_q[k][i] & gen_q[k][i-DIST]);
                    if (k < STAGES - 1) begin : g_prop
                        assign prop_q[k+1][i] = prop_q[k][i] & prop_q[k][i-DIST];
                    end
                end else begin : g_pass
                    // No lower group at this distance: keep the term.
                    assign gen_q[k+1][i] = gen_q[k][i];
                    if (k < STAGES - 1) begin : g_prop
                        assign prop_q[k+1][i] = prop_q[k][i];
                    end
                end
            end
        end
    endgenerate

    // Sum bits from the carries into each position.
    always_comb begin
        add_sum  = half_sum ^ {gen_q[STAGES][W-2:0], 1'b0};
        add_cout = gen_q[STAGES][W-1];
    end

    // Check the prefix result against a plain addition.
    always_comb begin
        AST_PREFIX_SUM: assert ({add_cout, add_sum} == (W+1)'(add_x) + (W+1)'(add_y))
            else $error("prefix adder mismatch"); // R5
    end

endmodule

// File: rtl/cmp42_pp_array.sv
// Module cmp42_pp_array
// Purpose: forms the partial products. Row r is the multiplicand shifted
//          left by r places, gated by multiplier bit r.
// Assumes: unsigned operands. Rows are padded with zeros to W = 2N bits.
module cmp42_pp_array #(
    parameter int unsigned N = 8,
    parameter int unsigned W = 2 * N
) (
    input  logic [N-1:0]   pp_mcand,
    input  logic [N-1:0]   pp_mplier,
    output logic [N*W-1:0] pp_rows
);

    generate
        for (genvar r = 0; r < N; r++) begin : g_row
            // AND gate row r, then align it to weight 2^r.
            assign pp_rows[r*W +: W] = (W'(pp_mcand) & {W{pp_mplier[r]}}) << r;
        end
    endgenerate

endmodule

// File: rtl/cmp42_mult.sv
// Module cmp42_mult
// Purpose: top of the unsigned multiplier. It links the AND array, the
//          (4,2) compressor tree and the prefix adder.
// Assumes: N is a power of two of at least 4. The block is combinational,
//          so the product follows the operands with no clock.
module cmp42_mult
    import cmp42_pkg::*;
#(
    parameter int unsigned N = CMP42_DEF_N
) (
    input  logic [N-1:0]   mcand,
    input  logic [N-1:0]   mplier,
    output logic [2*N-1:0] product
);

    localparam int unsigned W = 2 * N;

    logic [N*W-1:0] pp_rows;
    logic [W-1:0]   red_sum;
    logic [W-1:0]   red_carry;
    logic           final_cout;

    cmp42_pp_array #(.N(N), .W(W)) u_pp (
        .pp_mcand  (mcand),
        .pp_mplier (mplier),
        .pp_rows   (pp_rows)
    );

    cmp42_tree #(.W(W), .ROWS(N)) u_tree (
        .rows_in   (pp_rows),
        .out_sum   (red_sum),
        .out_carry (red_carry)
    );

    cmp42_prefix_add #(.W(W)) u_cpa (
        .add_x    (red_sum),
        .add_y    (red_carry),
        .add_sum  (product),
        .add_cout (final_cout)
    );

    // Check the whole datapath and confirm the result fits in 2N bits.
    always_comb begin
        AST_PRODUCT_EXACT: assert (product == W'(mcand) * W'(mplier))
            else $error("product mismatch"); // R1
        AST_NO_OVERFLOW: assert (!final_cout)
            else $error("carry out of top product bit"); // R6
    end

endmodule

// File: tb/test_cmp42_mult.sv
// Bench test_cmp42_mult
// Purpose: checks the multiplier. It walks a table of hand-computed
//          vectors, runs directed checks, and sweeps every operand pair.
//          The product is combinational: operands are driven after a
//          rising edge and sampled at the next falling edge.
module test_cmp42_mult;

    localparam int unsigned N = 8;
    localparam int unsigned W = 2 * N;
    localparam int unsigned NVEC = 16;

    // Each entry: {mcand, mplier, expected product}.
    localparam logic [31:0] VEC [NVEC] = '{
        {8'h00, 8'h00, 16'h0000},
        {8'hFF, 8'h00, 16'h0000},
        {8'hFF, 8'hFF, 16'hFE01},
        {8'hFE, 8'hFE, 16'hFC04},
        {8'h80, 8'h80, 16'h4000},
        {8'h10, 8'h10, 16'h0100},
        {8'h01, 8'hFF, 16'h00FF},
        {8'h80, 8'hFF, 16'h7F80},
        {8'h0F, 8'h0F, 16'h00E1},
        {8'hAA, 8'h55, 16'h3872},
        {8'h55, 8'h55, 16'h1C39},
        {8'hAA, 8'hAA, 16'h70E4},
        {8'h7F, 8'h7F, 16'h3F01},
        {8'hC3, 8'h3C, 16'h2DB4},
        {8'h12, 8'h34, 16'h03A8},
        {8'h01, 8'h01, 16'h0001}
    };
    localparam string VTAG [NVEC] = '{
        "R7", "R7", "R6", "R6", "R8", "R8", "R8", "R8",
        "R5", "R3", "R3", "R3", "R2", "R2", "R4", "R4"
    };

    logic         clk = 1'b0;
    logic [N-1:0] mcand = '0;
    logic [N-1:0] mplier = '0;
    logic [W-1:0] product;
    int           checks = 0;
    int           errors = 0;
    bit           done = 1'b0;

    always #4 clk = ~clk;

    cmp42_mult #(.N(N)) i_cmp42_mult (
        .mcand   (mcand),
        .mplier  (mplier),
        .product (product)
    );

    // Compare one sampled product with its expected value.
    task automatic check(input string tag, input logic [W-1:0] got, input logic [W-1:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: mcand=%h mplier=%h got %h expected %h", tag, mcand, mplier, got, exp);
        end
    endtask

    // Drive a pair after the rising edge and sample at the falling edge.
    task automatic apply(input logic [N-1:0] a, input logic [N-1:0] b,
                         input logic [W-1:0] exp, input string tag);
        @(posedge clk);
        mcand  = a;
        mplier = b;
        @(negedge clk);
        check(tag, product, exp);
    endtask

    // Main sequence: idle state, table, directed cases, full sweep.
    initial begin
        // Idle state: zero operands give a zero product.
        @(negedge clk);
        check("R7", product, '0);

        for (int v = 0; v < NVEC; v++) begin
            apply(VEC[v][31:24], VEC[v][23:16], VEC[v][15:0], VTAG[v]);
        end

        // R8: every power-of-two multiplier shifts the multiplicand.
        for (int k = 0; k < N; k++) begin
            apply(8'hB7, 8'(1 << k), W'(16'h00B7 << k), "R8");
        end
        // R7: zero multiplicand against a busy multiplier.
        apply(8'h00, 8'hE9, 16'h0000, "R7");

        // R1: every operand pair against a reference multiply.
        for (int a = 0; a < (1 << N); a++) begin
            for (int b = 0; b < (1 << N); b++) begin
                apply(N'(a), N'(b), W'(a * b), "R1");
            end
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run is counted as a failure and still reports.
    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule